// File: doc/BRIEF.md
# Accumulator Processor with Fetch-Execute Sequencer

A minimal single-accumulator processor that runs one instruction at a time. A fixed control sequence fetches a 16-bit word from memory, decodes it, and for memory-referencing instructions performs one data access before the next fetch starts. Every memory access goes through an address register. Every data word goes through a buffer register. The fetched word is latched into an instruction register.

The block drives a single word-wide synchronous memory port with one cycle of read latency. The memory returns data on the cycle after the read strobe. The block supports load, store, add and halt. It exposes its accumulator and program counter for debug, and it raises a halted flag that stays set until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the program counter and accumulator read 0, the halted output is 0, and the write enable is 0.
- R2: An instruction word carries its opcode in bits [15:12] and a direct 12-bit memory address in bits [11:0].
- R3: Opcode 4'b0001 copies the memory word at the operand address into the accumulator.
- R4: Opcode 4'b0010 writes the accumulator to the operand address. It pulses the write enable for exactly one cycle, and the write data equals the accumulator.
- R5: Opcode 4'b0101 adds the memory word at the operand address to the accumulator, modulo 2^16.
- R6: Load, store and add each take 6 cycles. The program counter advances by one per instruction fetched.
- R7: Opcode 4'b1111 raises the halted output 3 cycles after its fetch starts. After that the program counter, the accumulator and memory stay unchanged and no strobe is issued until reset.
- R8: Any other opcode is a no-operation that takes 3 cycles. Execution then goes on with the next word.
- R9: The program counter wraps from 4095 to 0.
- R10: Each fetch and each load or add issues exactly one read strobe. Read strobe and write enable are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory word address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the read strobe |
| mem_wdata_o | output | 16 | Write data |
| mem_we_o | output | 1 | Write enable |
| mem_rd_o | output | 1 | Read strobe |
| halted_o | output | 1 | Processor has stopped |
| dbg_acc_o | output | 16 | Accumulator value |
| dbg_pc_o | output | 12 | Program counter value |

## Verification
A wrong sequencer state shows at the ports within one instruction. Two symptoms make it visible: the halted flag rises on an edge other than the predicted one, or the number of read strobes and writes per program differs from the count given by the instruction mix. A wrong data-path register shows up as a wrong accumulator value or a wrong stored word once the program halts. A wrong program counter gives a halted-state counter other than the number of instructions executed. The bench sweeps 64 operand pairs that include carry-out cases, and it runs a no-operation mix and a full address-space wrap.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_WAIT,
    ST_DECODE,
    ST_EXEC_ADDR,
    ST_EXEC_WAIT,
    ST_EXEC_DONE,
    ST_HALT
  } cpu_state_e;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_STORE = 4'b0010;
  localparam logic [OP_W-1:0] OP_ADD   = 4'b0101;
  localparam logic [OP_W-1:0] OP_HALT  = 4'b1111;
endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] fetch_op_i,
  output cpu_state_e      state_o
);
  cpu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH_ADDR: state_d = ST_FETCH_WAIT;
      ST_FETCH_WAIT: state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (fetch_op_i)
          OP_LOAD, OP_STORE, OP_ADD: state_d = ST_EXEC_ADDR;
          OP_HALT:                   state_d = ST_HALT;
          default:                   state_d = ST_FETCH_ADDR; // no-op
        endcase
      end
      ST_EXEC_ADDR:  state_d = ST_EXEC_WAIT;
      ST_EXEC_WAIT:  state_d = ST_EXEC_DONE;
      ST_EXEC_DONE:  state_d = ST_FETCH_ADDR;
      default:       state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH_ADDR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_EXEC_FROM_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EXEC_ADDR |-> $past(state_q) == ST_DECODE); // R6
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cpu_state_e        state_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [OP_W-1:0]   ir_op_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q, acc_q;
  logic [OP_W-1:0]   op;

  assign op = ir_q[DATA_W-1 -: OP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      unique case (state_i)
        ST_FETCH_ADDR: mar_q <= pc_q;
        ST_DECODE: begin
          // buffer and instruction register load together; pc steps here
          mbr_q <= rdata_i;
          ir_q  <= rdata_i;
          pc_q  <= pc_q + ADDR_W'(1);
        end
        ST_EXEC_ADDR: begin
          mar_q <= ir_q[ADDR_W-1:0];
          if (op == OP_STORE) mbr_q <= acc_q;
        end
        ST_EXEC_DONE: begin
          if (op != OP_STORE) begin
            mbr_q <= rdata_i;
            acc_q <= (op == OP_LOAD) ? rdata_i : acc_q + rdata_i;
          end
        end
        default: ;
      endcase
    end
  end

  assign mar_o   = mar_q;
  assign mbr_o   = mbr_q;
  assign ir_op_o = op;
  assign acc_o   = acc_q;
  assign pc_o    = pc_q;

  AST_PC_ONLY_IN_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q != $past(pc_q) |-> $past(state_i) == ST_DECODE); // R6
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_rd_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] dbg_acc_o,
  output logic [ADDR_W-1:0] dbg_pc_o
);
  cpu_state_e      state;
  logic [OP_W-1:0] ir_op;
  logic            exec_wait;

  acc_cpu_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_op_i (mem_rdata_i[DATA_W-1 -: OP_W]),
    .state_o    (state)
  );

  acc_cpu_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .rdata_i (mem_rdata_i),
    .mar_o   (mem_addr_o),
    .mbr_o   (mem_wdata_o),
    .ir_op_o (ir_op),
    .acc_o   (dbg_acc_o),
    .pc_o    (dbg_pc_o)
  );

  assign exec_wait = (state == ST_EXEC_WAIT);
  assign mem_rd_o  = (state == ST_FETCH_WAIT) || (exec_wait && ir_op != OP_STORE);
  assign mem_we_o  = exec_wait && ir_op == OP_STORE;
  assign halted_o  = (state == ST_HALT);

  AST_RD_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o)); // R10
  AST_WE_CARRIES_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o == dbg_acc_o); // R4
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R4
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(dbg_pc_o) && $stable(dbg_acc_o)); // R7
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_rd_o && !mem_we_o); // R7
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] mem_addr_o, dbg_pc_o;
  logic [15:0] mem_rdata_i, mem_wdata_o, dbg_acc_o;
  logic        mem_we_o, mem_rd_o, halted_o;

  logic [15:0] mem [4096];
  int          n_chk = 0, n_bad = 0, rd_cnt, we_cnt, cyc = 0;

  always #5 clk_i = ~clk_i;

  acc_cpu u0 (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (!rst_ni) begin
      rd_cnt <= 0;
      we_cnt <= 0;
    end else begin
      rd_cnt <= rd_cnt + int'(mem_rd_o);
      we_cnt <= we_cnt + int'(mem_we_o);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wipe();
    rst_ni = 1'b0;
    for (int k = 0; k < 4096; k++) mem[k] = 16'h0;
  endtask

  task automatic release_reset();
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    mem_rdata_i = '0;
    // R1: reset state
    wipe();
    edges(2);
    chk("R1 pc", int'(dbg_pc_o), 0);
    chk("R1 acc", int'(dbg_acc_o), 0);
    chk("R1 halted", int'(halted_o), 0);
    chk("R1 we", int'(mem_we_o), 0);

    // R2..R7, R10: sweep of operand pairs through load/add/store/halt
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] a, b, s;
        logic [11:0] pa, pb, pc;
        a  = 16'(i * 16'h3001 + j);
        b  = 16'(16'hFFFF - j * 16'h1111 + i);
        s  = a + b;
        pa = 12'(12'h100 + i * 64 + j * 4);
        pb = pa + 12'd1;
        pc = 12'(12'hF00 + i * 8 + j);
        wipe();
        mem[0] = {4'b0001, pa};
        mem[1] = {4'b0101, pb};
        mem[2] = {4'b0010, pc};
        mem[3] = {4'b1111, 12'hABC};
        mem[pa] = a;
        mem[pb] = b;
        release_reset();
        edges(20);
        chk("R6 halt not yet at 20", int'(halted_o), 0);
        edges(1);
        chk("R7 halted at 21", int'(halted_o), 1);
        chk("R3/R5 acc sum", int'(dbg_acc_o), int'(s));
        chk("R4 stored word", int'(mem[pc]), int'(s));
        chk("R6 pc count", int'(dbg_pc_o), 4);
        edges(10);
        chk("R7 pc frozen", int'(dbg_pc_o), 4);
        chk("R7 acc frozen", int'(dbg_acc_o), int'(s));
        chk("R10 reads", rd_cnt, 6);
        chk("R4 one write", we_cnt, 1);
        chk("R2 operand untouched", int'(mem[pa]), int'(a));
      end
    end

    // R8: undefined opcodes are no-ops
    wipe();
    mem[0] = {4'b0001, 12'h400};
    mem[1] = {4'b0011, 12'h400};
    mem[2] = {4'b0000, 12'h401};
    mem[3] = {4'b1110, 12'h400};
    mem[4] = {4'b0101, 12'h401};
    mem[5] = {4'b1111, 12'h000};
    mem[12'h400] = 16'h1234;
    mem[12'h401] = 16'h0F0F;
    release_reset();
    edges(23);
    chk("R8 not halted at 23", int'(halted_o), 0);
    edges(1);
    chk("R8 halted at 24", int'(halted_o), 1);
    chk("R8 acc", int'(dbg_acc_o), 16'h1234 + 16'h0F0F);
    chk("R8 pc", int'(dbg_pc_o), 6);
    chk("R8 reads", rd_cnt, 8);
    chk("R8 no write", we_cnt, 0);

    // R9: pc wraps 4095 -> 0
    wipe();
    mem[0] = {4'b0101, 12'hFA0};
    mem[12'hFA0] = 16'h0001;
    release_reset();
    edges(7);
    chk("R9 first add", int'(dbg_acc_o), 1);
    begin
      int w = 0;
      while (dbg_acc_o != 16'd2 && w < 20000) begin
        edges(1);
        w++;
      end
      chk("R9 wrap re-executes word 0", int'(dbg_acc_o), 2);
      chk("R9 pc after wrap", int'(dbg_pc_o), 1);
      chk("R9 wrap cycle count", w + 7, 6 + 4095 * 3 + 6);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule